// File: doc/BRIEF.md
# IQ Decimator with DC Removal

This block turns counter snapshots from a one-bit quadrature mixer into a stream of 8-bit complex samples. Each input beat carries, for both the in-phase (I) and quadrature (Q) channel, a count of negative hits and a count of positive hits over one half-sample period. Two consecutive beats make one output sample per channel. Each channel runs a 1-2-1 smoothing decimator that reuses the previous half-sample. It then removes DC with a leaky tracker that keeps 16 fractional bits. Finally it scales the sample by a gain, divides by a normalising divisor, saturates to signed 8 bits and converts to offset binary.

The bytes leave one per cycle with I first and Q second. A marker flags the last byte of every block of 64 bytes (32 I/Q pairs). The upstream counter logic feeds beats with `in_valid`. The consumer takes `out_byte` whenever `out_valid` is high. No back-pressure exists, because each two-beat sample produces exactly two output bytes.

Top module: `iq_decim`

## Requirements
- R1: Each beat forms a half-sample per channel as neg count minus pos count, taken as signed. Beats alternate from reset: the first of a pair is x1 and the second is x2.
- R2: On the second beat a channel forms s = (prev + 2*x1 + x2) / 2, truncated toward zero. prev is the x2 of that channel's previous pair, and x2 then becomes the new prev.
- R3: The DC state updates as dc = ((dc<<16) - dc + (s<<16)) >> 16. The corrected sample is ((s<<16) - dc) >> 16 using the updated dc. Both shifts are arithmetic, so they round toward minus infinity.
- R4: The corrected sample is multiplied by the unsigned `gain` and divided by the unsigned divisor. The quotient is truncated toward zero.
- R5: A `divisor` input of zero is not used. The block divides by the last nonzero value seen, which is 1 after reset.
- R6: The quotient saturates to -128..127 and is emitted as value + 128.
- R7: The I byte appears the cycle after the accepted second beat and the Q byte the cycle after that. `out_valid` is high only in those cycles.
- R8: `out_last` is high exactly with every 64th byte emitted since reset, and never without `out_valid`.
- R9: Reset clears prev, dc, the beat phase and the byte count, and it drives `out_valid` and `out_last` low.
- R10: I and Q keep separate prev and dc state, so one channel's input never changes the other's bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A half-sample beat is present |
| in_i_neg | input | CNT_W | I channel negative count |
| in_i_pos | input | CNT_W | I channel positive count |
| in_q_neg | input | CNT_W | Q channel negative count |
| in_q_pos | input | CNT_W | Q channel positive count |
| gain | input | GAIN_W | Unsigned gain multiplier |
| divisor | input | DIV_W | Unsigned normalising divisor; zero means keep the last one |
| out_valid | output | 1 | `out_byte` holds a sample byte |
| out_byte | output | 8 | Offset-binary sample, I then Q |
| out_last | output | 1 | Marks the final byte of a 64-byte block |

## Verification
The assertions watch the output slot timing on every cycle. After each second beat, the I slot and the Q slot must follow in the next two cycles, and no byte may appear outside those slots. They also check that the block marker falls only on every 64th emitted byte and never without a valid byte. The arithmetic itself is only visible through the bench's scenarios. Those scenarios cover the decimation with its carried prev, the slow convergence of the DC tracker under a constant input, saturation at both rails, a zero divisor, and independent I and Q streams. The bench compares each of these against its own integer model.

// File: rtl/iq_decim_pkg.sv
package iq_decim_pkg;
    // fractional bits of the leaky DC tracker
    parameter int DC_FRAC = 16;
    // bytes produced per decimated sample (I then Q)
    parameter int NUM_CH = 2;

    typedef logic [7:0] sample_byte_t;
endpackage

// File: rtl/iq_chan.sv
module iq_chan
    import iq_decim_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int C_W  = CNT_W + 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  beat_valid,
    input  logic                  beat_second,
    input  logic [CNT_W-1:0]      cnt_neg,
    input  logic [CNT_W-1:0]      cnt_pos,
    output logic signed [C_W-1:0] corr_o
);
    localparam int XW    = CNT_W + 1;
    localparam int SUM_W = CNT_W + 3;
    localparam int SW    = CNT_W + 2;
    localparam int DC_W  = SW + DC_FRAC + 1;
    localparam int T_W   = DC_W + DC_FRAC + 2;

    typedef struct packed {
        logic signed [XW-1:0]   x1;
        logic signed [XW-1:0]   prev;
        logic signed [DC_W-1:0] dc;
    } chan_state_t;

    chan_state_t st_d, st_q;

    logic signed [XW-1:0]    half_x;
    logic signed [SUM_W-1:0] tap_sum;
    logic signed [SW-1:0]    smp;
    logic signed [T_W-1:0]   dc_acc;
    logic signed [DC_W-1:0]  dc_new;
    logic signed [T_W-1:0]   diff;

    always_comb begin
        half_x  = $signed({1'b0, cnt_neg}) - $signed({1'b0, cnt_pos});
        tap_sum = SUM_W'(st_q.prev) + (SUM_W'(st_q.x1) <<< 1) + SUM_W'(half_x);
        smp     = SW'(tap_sum / 2);
        dc_acc  = (T_W'(st_q.dc) <<< DC_FRAC) - T_W'(st_q.dc) + (T_W'(smp) <<< DC_FRAC);
        dc_new  = DC_W'(dc_acc >>> DC_FRAC);
        diff    = (T_W'(smp) <<< DC_FRAC) - T_W'(dc_new);
        corr_o  = C_W'(diff >>> DC_FRAC);

        st_d = st_q;
        if (beat_valid) begin
            if (!beat_second) begin
                st_d.x1 = half_x;
            end else begin
                st_d.prev = half_x;
                st_d.dc   = dc_new;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/iq_scale.sv
module iq_scale
    import iq_decim_pkg::*;
#(
    parameter int C_W    = 20,
    parameter int GAIN_W = 12,
    parameter int DIV_W  = 16
) (
    input  logic signed [C_W-1:0] corr,
    input  logic [GAIN_W-1:0]     gain,
    input  logic [DIV_W-1:0]      divisor,
    output sample_byte_t          byte_o
);
    localparam int P_W = C_W + GAIN_W + 1;

    logic signed [P_W-1:0] prod;
    logic signed [P_W-1:0] quo;
    logic signed [7:0]     sat;

    always_comb begin
        prod = P_W'(corr) * $signed(P_W'({1'b0, gain}));
        quo  = prod / $signed(P_W'({1'b0, divisor}));
        if (quo > $signed(P_W'(127)))        sat = 8'sd127;
        else if (quo < $signed(-P_W'(128)))  sat = -8'sd128;
        else                                 sat = quo[7:0];
        byte_o = {~sat[7], sat[6:0]};
    end
endmodule

// File: rtl/iq_framer.sv
module iq_framer
    import iq_decim_pkg::*;
#(
    parameter int BLOCK_PAIRS = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fire,
    input  sample_byte_t byte_i,
    input  sample_byte_t byte_q,
    output logic         out_valid,
    output sample_byte_t out_byte,
    output logic         out_last
);
    localparam int BLOCK_BYTES = NUM_CH * BLOCK_PAIRS;
    localparam int CNT_BITS    = $clog2(BLOCK_BYTES);

    typedef struct packed {
        logic                valid;
        sample_byte_t        data;
        logic                last;
        logic                pend_valid;
        sample_byte_t        pend_data;
        logic [CNT_BITS-1:0] cnt;
    } frame_state_t;

    frame_state_t fr_d, fr_q;
    logic         emit;

    always_comb begin
        fr_d       = fr_q;
        fr_d.valid = 1'b0;
        fr_d.last  = 1'b0;
        emit       = 1'b0;
        if (fire) begin
            emit            = 1'b1;
            fr_d.data       = byte_i;
            fr_d.pend_valid = 1'b1;
            fr_d.pend_data  = byte_q;
        end else if (fr_q.pend_valid) begin
            emit            = 1'b1;
            fr_d.data       = fr_q.pend_data;
            fr_d.pend_valid = 1'b0;
        end
        if (emit) begin
            fr_d.valid = 1'b1;
            if (fr_q.cnt == CNT_BITS'(BLOCK_BYTES - 1)) begin
                fr_d.last = 1'b1;
                fr_d.cnt  = '0;
            end else begin
                fr_d.cnt = fr_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fr_q <= '0;
        else        fr_q <= fr_d;
    end

    assign out_valid = fr_q.valid;
    assign out_byte  = fr_q.data;
    assign out_last  = fr_q.last;
endmodule

// File: rtl/iq_decim.sv
module iq_decim
    import iq_decim_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int GAIN_W      = 12,
    parameter int DIV_W       = 16,
    parameter int BLOCK_PAIRS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CNT_W-1:0]  in_i_neg,
    input  logic [CNT_W-1:0]  in_i_pos,
    input  logic [CNT_W-1:0]  in_q_neg,
    input  logic [CNT_W-1:0]  in_q_pos,
    input  logic [GAIN_W-1:0] gain,
    input  logic [DIV_W-1:0]  divisor,
    output logic              out_valid,
    output logic [7:0]        out_byte,
    output logic              out_last
);
    localparam int C_W = CNT_W + 4;

    typedef struct packed {
        logic             second;
        logic [DIV_W-1:0] div_hold;
    } ctl_state_t;

    ctl_state_t ctl_d, ctl_q;
    logic [DIV_W-1:0] div_eff;
    logic             fire;

    logic [CNT_W-1:0]      neg_a  [NUM_CH];
    logic [CNT_W-1:0]      pos_a  [NUM_CH];
    logic signed [C_W-1:0] corr_a [NUM_CH];
    sample_byte_t          byte_a [NUM_CH];

    assign neg_a[0] = in_i_neg;
    assign pos_a[0] = in_i_pos;
    assign neg_a[1] = in_q_neg;
    assign pos_a[1] = in_q_pos;

    always_comb begin
        ctl_d   = ctl_q;
        div_eff = (divisor != '0) ? divisor : ctl_q.div_hold;
        fire    = in_valid && ctl_q.second;
        if (divisor != '0) ctl_d.div_hold = divisor;
        if (in_valid)      ctl_d.second   = ~ctl_q.second;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.second   <= 1'b0;
            ctl_q.div_hold <= DIV_W'(1);
        end else begin
            ctl_q <= ctl_d;
        end
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        iq_chan #(.CNT_W(CNT_W)) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .beat_valid  (in_valid),
            .beat_second (ctl_q.second),
            .cnt_neg     (neg_a[ch]),
            .cnt_pos     (pos_a[ch]),
            .corr_o      (corr_a[ch])
        );
        iq_scale #(.C_W(C_W), .GAIN_W(GAIN_W), .DIV_W(DIV_W)) u_scale (
            .corr    (corr_a[ch]),
            .gain    (gain),
            .divisor (div_eff),
            .byte_o  (byte_a[ch])
        );
    end

    iq_framer #(.BLOCK_PAIRS(BLOCK_PAIRS)) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .byte_i    (byte_a[0]),
        .byte_q    (byte_a[1]),
        .out_valid (out_valid),
        .out_byte  (out_byte),
        .out_last  (out_last)
    );
endmodule

// File: rtl/iq_decim_chk.sv
module iq_decim_chk #(
    parameter int BLOCK_PAIRS = 32
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic out_valid,
    input logic out_last
);
    localparam int BLOCK_BYTES = 2 * BLOCK_PAIRS;
    localparam int CB = $clog2(BLOCK_BYTES);

    logic          par_q;
    logic [CB-1:0] seen_q;
    logic          pair_done;

    assign pair_done = in_valid && par_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_q  <= 1'b0;
            seen_q <= '0;
        end else begin
            if (in_valid) par_q <= ~par_q;
            if (out_valid) seen_q <= (seen_q == CB'(BLOCK_BYTES - 1)) ? '0 : seen_q + 1'b1;
        end
    end

    assert_last_has_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    assert_last_position_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_last == (seen_q == CB'(BLOCK_BYTES - 1))));

    assert_i_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pair_done |=> out_valid);

    assert_q_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pair_done |=> ##1 out_valid);

    assert_no_stray_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(pair_done) || $past(pair_done, 2)));
endmodule

bind iq_decim iq_decim_chk #(.BLOCK_PAIRS(BLOCK_PAIRS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_last  (out_last)
);

// File: tb/sim_iq_decim.sv
module sim_iq_decim;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_i_neg = '0, in_i_pos = '0, in_q_neg = '0, in_q_pos = '0;
    logic [11:0] gain = 12'd120;
    logic [15:0] divisor = 16'd750;
    logic        out_valid;
    logic [7:0]  out_byte;
    logic        out_last;

    always #(CLK_PERIOD/2) clk = ~clk;

    iq_decim u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_i_neg(in_i_neg), .in_i_pos(in_i_pos),
        .in_q_neg(in_q_neg), .in_q_pos(in_q_pos),
        .gain(gain), .divisor(divisor),
        .out_valid(out_valid), .out_byte(out_byte), .out_last(out_last)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // scoreboard
    logic [7:0] exp_byte_q[$];
    bit         exp_last_q[$];
    int         exp_cyc_q[$];
    string      exp_tag_q[$];

    // reference model state
    longint m_prev[2];
    longint m_dc[2];
    longint m_div = 1;
    int     m_bytes = 0;
    int unsigned seed = 32'h1234_5678;

    function automatic int unsigned lcg();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed >> 8;
    endfunction

    function automatic logic [7:0] model(int ch, longint x1, longint x2, longint g, longint dv);
        longint s, c, v;
        s = (m_prev[ch] + 2 * x1 + x2) / 2;
        m_prev[ch] = x2;
        m_dc[ch] = ((m_dc[ch] <<< 16) - m_dc[ch] + (s <<< 16)) >>> 16;
        c = ((s <<< 16) - m_dc[ch]) >>> 16;
        v = (c * g) / dv;
        if (v > 127) v = 127;
        else if (v < -128) v = -128;
        return 8'(v + 128);
    endfunction

    task automatic check(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one I/Q pair: two beats, then expected bytes pushed to the scoreboard
    task automatic send_pair(int in1, int ip1, int qn1, int qp1,
                             int in2, int ip2, int qn2, int qp2, string tag);
        longint dv;
        int c0;
        @(negedge clk);
        in_valid = 1'b1;
        in_i_neg = 16'(in1); in_i_pos = 16'(ip1);
        in_q_neg = 16'(qn1); in_q_pos = 16'(qp1);
        @(negedge clk);
        in_i_neg = 16'(in2); in_i_pos = 16'(ip2);
        in_q_neg = 16'(qn2); in_q_pos = 16'(qp2);
        c0 = cyc;
        if (divisor != 0) m_div = longint'(divisor);
        dv = m_div;
        for (int ch = 0; ch < 2; ch++) begin
            logic [7:0] b;
            if (ch == 0) b = model(0, longint'(in1 - ip1), longint'(in2 - ip2), longint'(gain), dv);
            else         b = model(1, longint'(qn1 - qp1), longint'(qn2 - qp2), longint'(gain), dv);
            m_bytes++;
            exp_byte_q.push_back(b);
            exp_last_q.push_back((m_bytes % 64) == 0);
            exp_cyc_q.push_back(c0 + 1 + ch);
            exp_tag_q.push_back(ch == 0 ? tag : {tag, " R10"});
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic rand_pair(string tag);
        send_pair(int'(lcg() % 4000) + 1000, int'(lcg() % 4000) + 1000,
                  int'(lcg() % 4000) + 1000, int'(lcg() % 4000) + 1000,
                  int'(lcg() % 4000) + 1000, int'(lcg() % 4000) + 1000,
                  int'(lcg() % 4000) + 1000, int'(lcg() % 4000) + 1000, tag);
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_byte_q.size() == 0) begin
                check(1'b0, "R7 byte with nothing expected", 1, 0);
            end else begin
                logic [7:0] eb;
                bit el;
                int ec;
                string et;
                eb = exp_byte_q.pop_front();
                el = exp_last_q.pop_front();
                ec = exp_cyc_q.pop_front();
                et = exp_tag_q.pop_front();
                check(out_byte == eb, {et, " R1 R2 R3 R4 R6 byte"}, out_byte, eb);
                check(out_last == el, "R8 block marker", out_last, el);
                check(cyc == ec, "R7 slot cycle", cyc, ec);
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog expired", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        m_prev[0] = 0; m_prev[1] = 0; m_dc[0] = 0; m_dc[1] = 0;
        repeat (4) @(negedge clk);
        check(out_valid == 1'b0, "R9 reset out_valid", out_valid, 0);
        check(out_last == 1'b0, "R9 reset out_last", out_last, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R9 idle after reset", out_valid, 0);

        // first pair sees cleared prev and dc
        send_pair(3000, 1000, 1000, 3000, 2500, 1500, 1200, 2800, "R9 first pair");

        // varied traffic, back to back and with gaps
        for (int k = 0; k < 30; k++) rand_pair("R2 random");
        for (int k = 0; k < 6; k++) begin
            rand_pair("R1 gapped");
            repeat (int'(lcg() % 4)) @(negedge clk);
        end

        // constant offset: DC tracker slowly absorbs it
        gain = 12'd4000; divisor = 16'd40;
        for (int k = 0; k < 12; k++)
            send_pair(9000, 1000, 1000, 9000, 9000, 1000, 1000, 9000, "R3 constant DC");

        // rail saturation on sudden swings
        gain = 12'd4095; divisor = 16'd2;
        send_pair(60000, 0, 0, 60000, 60000, 0, 0, 60000, "R6 clamp");
        send_pair(0, 60000, 60000, 0, 0, 60000, 60000, 0, "R6 clamp");
        send_pair(0, 65535, 65535, 0, 0, 65535, 65535, 0, "R6 clamp");

        // zero divisor keeps the last nonzero one
        gain = 12'd300; divisor = 16'd7;
        send_pair(2000, 1000, 1500, 1000, 1800, 1000, 1100, 1600, "R5 before zero");
        divisor = 16'd0;
        for (int k = 0; k < 4; k++) rand_pair("R5 zero divisor");

        // negative rounding of truncating division and arithmetic shifts
        gain = 12'd7; divisor = 16'd3;
        for (int k = 0; k < 20; k++)
            send_pair(1000, 1003 + k, 1005, 1000 + k, 1000, 1004, 1001 + k, 1000, "R4 truncation");

        repeat (8) @(negedge clk);
        check(exp_byte_q.size() == 0, "R7 all expected bytes seen", exp_byte_q.size(), 0);
        check(out_valid == 1'b0, "R7 quiet when idle", out_valid, 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule